// File: doc/BRIEF.md
# Accumulator Processor Core with Skip Branching

This block is a small multi-cycle processor built around one 32-bit accumulator. Every access to memory passes through an address register and a data register. Instruction fetch uses them, and so do operand reads and stores. The core reads one 32-bit instruction word, advances its program counter, and then executes the instruction. It runs arithmetic, logic, load, store and jump operations against a word-addressed synchronous memory.

The core has no compare-and-branch instruction. Conditional flow uses three skip instructions, which step over the next word when the accumulator is zero, positive or negative. A byte-wide input channel and a byte-wide output channel carry characters, each with a valid/ready handshake. The core stalls on either channel until the other side is ready. When the core stops, the halted flag rises and stays high until reset.

Top module: `acc_cpu`

## Requirements
- R1: An instruction word carries its opcode in bits 31:24 and an operand in bits 23:0. Opcode 0 (load literal) puts the operand field, zero-extended to 32 bits, into the accumulator and makes no memory access.
- R2: Instructions run in address order: each fetch reads memory at the program counter, and the counter then advances by one before the instruction executes.
- R3: Opcodes 1 (load), 3 (add), 4 (subtract), 12 (OR) and 13 (AND) read memory at the operand address. They then replace the accumulator with the word read, or combine the accumulator with it. Arithmetic wraps modulo 2^32.
- R4: Opcode 2 (store) writes the accumulator to memory at the operand address, using exactly one write cycle.
- R5: Opcode 8 (jump) loads the program counter with the operand address.
- R6: flag_zero is high when the accumulator is 0. flag_neg is high when bit 31 is set. flag_pos is high when the accumulator is nonzero and bit 31 is clear. Exactly one of the three is high at any time.
- R7: Opcodes 9, 10 and 11 skip the following instruction when flag_zero, flag_pos or flag_neg is high, in that order. Otherwise execution falls through to the next instruction.
- R8: Opcode 14 inverts all 32 accumulator bits and ignores the operand field.
- R9: Opcode 5 holds in_ready high until in_valid is seen. It then loads the 8-bit character, zero-extended, into the accumulator.
- R10: Opcode 6 drives the accumulator's low 8 bits on out_char with out_valid high, and holds both steady until out_ready is high.
- R11: Opcode 7 and every undefined opcode (15 to 255) stop the core. At that point halted is high, the program counter points one past the halting word, and no further memory access occurs.
- R12: While reset is asserted, the program counter, the accumulator and halted are zero and the memory strobes are low. The first fetch after reset reads address 0.
- R13: mem_rd_en and mem_wr_en are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized inside |
| mem_addr | output | ADDR_W | Word address for memory read or write |
| mem_rd_en | output | 1 | Read strobe; data is returned on mem_rdata the next cycle |
| mem_wr_en | output | 1 | Write strobe for mem_wdata at mem_addr |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data from memory |
| in_char | input | 8 | Input character |
| in_valid | input | 1 | Input character present |
| in_ready | output | 1 | Core is waiting to take a character |
| out_char | output | 8 | Output character |
| out_valid | output | 1 | Output character present |
| out_ready | input | 1 | Sink accepts the character |
| halted | output | 1 | Core has stopped |
| prog_counter | output | ADDR_W | Current program counter |
| acc_value | output | 32 | Current accumulator |
| flag_zero | output | 1 | Accumulator is zero |
| flag_pos | output | 1 | Accumulator is positive |
| flag_neg | output | 1 | Accumulator is negative |

## Verification
Some properties must hold on every cycle, and the assertions cover these. They check that the three condition flags stay mutually exclusive and complete, and that a read and a write never coincide. They also check that a stalled input or output handshake keeps its strobe and its character steady, and that a halted core stays silent on the memory port. The instruction semantics can only be shown by the bench's programs: arithmetic wrap and sign results, taken and untaken skips, jump targets, character zero-extension, and the program counter after halting on a legal or an undefined opcode.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OPC_W = 8;

  localparam logic [OPC_W-1:0] OP_LIT = 8'd0;
  localparam logic [OPC_W-1:0] OP_LOD = 8'd1;
  localparam logic [OPC_W-1:0] OP_STO = 8'd2;
  localparam logic [OPC_W-1:0] OP_ADD = 8'd3;
  localparam logic [OPC_W-1:0] OP_SUB = 8'd4;
  localparam logic [OPC_W-1:0] OP_CIN = 8'd5;
  localparam logic [OPC_W-1:0] OP_COU = 8'd6;
  localparam logic [OPC_W-1:0] OP_HLT = 8'd7;
  localparam logic [OPC_W-1:0] OP_JMP = 8'd8;
  localparam logic [OPC_W-1:0] OP_SKZ = 8'd9;
  localparam logic [OPC_W-1:0] OP_SKG = 8'd10;
  localparam logic [OPC_W-1:0] OP_SKL = 8'd11;
  localparam logic [OPC_W-1:0] OP_OR  = 8'd12;
  localparam logic [OPC_W-1:0] OP_AND = 8'd13;
  localparam logic [OPC_W-1:0] OP_NOT = 8'd14;

  typedef enum logic [2:0] {
    ALU_PASS, ALU_ADD, ALU_SUB, ALU_OR, ALU_AND, ALU_INV
  } alu_op_e;

  typedef enum logic [3:0] {
    ST_FADDR,   // address register <- program counter
    ST_FREAD,   // instruction read strobe
    ST_FLATCH,  // data register <- memory
    ST_DECODE,  // instruction register <- data register, counter + 1
    ST_EXEC,    // per-opcode action
    ST_OREAD,   // operand read strobe
    ST_OLATCH,  // data register <- memory
    ST_OALU,    // accumulator <- alu result
    ST_SWRITE,  // store write strobe
    ST_HALT
  } seq_state_e;
endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_OR:  y = a | b;
      ALU_AND: y = a & b;
      ALU_INV: y = ~a;
      default: y = b;
    endcase
  end
endmodule

// File: rtl/acc_flags.sv
module acc_flags #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] acc,
  output logic              z,
  output logic              g,
  output logic              l
);
  always_comb begin
    z = (acc == '0);
    l = acc[DATA_W-1];
    g = !z && !acc[DATA_W-1];
  end
endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [CHAR_W-1:0] in_char,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [CHAR_W-1:0] out_char,
  output logic              out_valid,
  input  logic              out_ready,
  input  logic              flag_z,
  input  logic              flag_g,
  input  logic              flag_l,
  output alu_op_e           alu_op,
  output logic [DATA_W-1:0] alu_b,
  input  logic [DATA_W-1:0] alu_y,
  output logic              halted,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] acc
);
  localparam int FIELD_W = DATA_W - OPC_W;

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] pc_q, pc_d, mar_q, mar_d;
  logic [DATA_W-1:0] mdr_q, mdr_d, ir_q, ir_d, acc_q, acc_d;
  logic              halt_q, halt_d;
  logic              pc_en, mar_en, mdr_en, ir_en, acc_en;

  logic [OPC_W-1:0]   opc;
  logic [FIELD_W-1:0] field;
  logic [ADDR_W-1:0]  op_addr;
  logic [ADDR_W-1:0]  pc_inc;

  assign opc     = ir_q[DATA_W-1 -: OPC_W];
  assign field   = ir_q[FIELD_W-1:0];
  assign op_addr = field[ADDR_W-1:0];
  assign pc_inc  = pc_q + ADDR_W'(1);

  always_comb begin
    case (opc)
      OP_ADD:  alu_op = ALU_ADD;
      OP_SUB:  alu_op = ALU_SUB;
      OP_OR:   alu_op = ALU_OR;
      OP_AND:  alu_op = ALU_AND;
      OP_NOT:  alu_op = ALU_INV;
      default: alu_op = ALU_PASS;
    endcase
  end
  assign alu_b = mdr_q;

  // next-state and clock-enable logic
  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;   pc_en  = 1'b0;
    mar_d   = mar_q;  mar_en = 1'b0;
    mdr_d   = mdr_q;  mdr_en = 1'b0;
    ir_d    = ir_q;   ir_en  = 1'b0;
    acc_d   = acc_q;  acc_en = 1'b0;
    halt_d  = halt_q;
    case (state_q)
      ST_FADDR: begin
        mar_d = pc_q; mar_en = 1'b1;
        state_d = ST_FREAD;
      end
      ST_FREAD:  state_d = ST_FLATCH;
      ST_FLATCH: begin
        mdr_d = mem_rdata; mdr_en = 1'b1;
        state_d = ST_DECODE;
      end
      ST_DECODE: begin
        ir_d = mdr_q;   ir_en = 1'b1;
        pc_d = pc_inc;  pc_en = 1'b1;
        state_d = ST_EXEC;
      end
      ST_EXEC: begin
        state_d = ST_FADDR;
        case (opc)
          OP_LIT: begin
            acc_d = DATA_W'(field); acc_en = 1'b1;
          end
          OP_LOD, OP_ADD, OP_SUB, OP_OR, OP_AND: begin
            mar_d = op_addr; mar_en = 1'b1;
            state_d = ST_OREAD;
          end
          OP_STO: begin
            mar_d = op_addr; mar_en = 1'b1;
            mdr_d = acc_q;   mdr_en = 1'b1;
            state_d = ST_SWRITE;
          end
          OP_CIN: begin
            if (in_valid) begin
              acc_d = DATA_W'(in_char); acc_en = 1'b1;
            end else begin
              state_d = ST_EXEC;
            end
          end
          OP_COU: begin
            if (!out_ready) state_d = ST_EXEC;
          end
          OP_JMP: begin
            pc_d = op_addr; pc_en = 1'b1;
          end
          OP_SKZ: begin
            pc_d = pc_inc; pc_en = flag_z;
          end
          OP_SKG: begin
            pc_d = pc_inc; pc_en = flag_g;
          end
          OP_SKL: begin
            pc_d = pc_inc; pc_en = flag_l;
          end
          OP_NOT: begin
            acc_d = alu_y; acc_en = 1'b1;
          end
          default: begin
            halt_d  = 1'b1;
            state_d = ST_HALT;
          end
        endcase
      end
      ST_OREAD:  state_d = ST_OLATCH;
      ST_OLATCH: begin
        mdr_d = mem_rdata; mdr_en = 1'b1;
        state_d = ST_OALU;
      end
      ST_OALU: begin
        acc_d = alu_y; acc_en = 1'b1;
        state_d = ST_FADDR;
      end
      ST_SWRITE: state_d = ST_FADDR;
      default:   state_d = ST_HALT;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FADDR;
      pc_q    <= '0;
      mar_q   <= '0;
      mdr_q   <= '0;
      ir_q    <= '0;
      acc_q   <= '0;
      halt_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      halt_q  <= halt_d;
      if (pc_en)  pc_q  <= pc_d;
      if (mar_en) mar_q <= mar_d;
      if (mdr_en) mdr_q <= mdr_d;
      if (ir_en)  ir_q  <= ir_d;
      if (acc_en) acc_q <= acc_d;
    end
  end

  assign mem_addr  = mar_q;
  assign mem_rd_en = (state_q == ST_FREAD) || (state_q == ST_OREAD);
  assign mem_wr_en = (state_q == ST_SWRITE);
  assign mem_wdata = mdr_q;
  assign in_ready  = (state_q == ST_EXEC) && (opc == OP_CIN);
  assign out_valid = (state_q == ST_EXEC) && (opc == OP_COU);
  assign out_char  = acc_q[CHAR_W-1:0];
  assign halted    = halt_q;
  assign pc        = pc_q;
  assign acc       = acc_q;

  // R13: the memory port never reads and writes together
  assert_rw_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

  // R11: a stopped core stays stopped and leaves memory alone
  assert_halt_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !mem_rd_en && !mem_wr_en));

  // R9: input wait persists until a character is offered
  assert_in_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> in_ready);

  // R10: offered character is held until taken
  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_char)));
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [CHAR_W-1:0] in_char,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [CHAR_W-1:0] out_char,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              halted,
  output logic [ADDR_W-1:0] prog_counter,
  output logic [DATA_W-1:0] acc_value,
  output logic              flag_zero,
  output logic              flag_pos,
  output logic              flag_neg
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   core_rst_n;
  alu_op_e                alu_op;
  logic [DATA_W-1:0]      alu_b, alu_y;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[SYNC_STAGES-1];

  acc_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CHAR_W(CHAR_W)) seq_i (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .mem_addr  (mem_addr),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .in_char   (in_char),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_char  (out_char),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .flag_z    (flag_zero),
    .flag_g    (flag_pos),
    .flag_l    (flag_neg),
    .alu_op    (alu_op),
    .alu_b     (alu_b),
    .alu_y     (alu_y),
    .halted    (halted),
    .pc        (prog_counter),
    .acc       (acc_value)
  );

  acc_alu #(.DATA_W(DATA_W)) alu_i (
    .op (alu_op),
    .a  (acc_value),
    .b  (alu_b),
    .y  (alu_y)
  );

  acc_flags #(.DATA_W(DATA_W)) flags_i (
    .acc (acc_value),
    .z   (flag_zero),
    .g   (flag_pos),
    .l   (flag_neg)
  );

  // R6: condition flags are exclusive and complete
  assert_flag_onehot_R6: assert property (@(posedge clk) disable iff (!core_rst_n)
    $countones({flag_zero, flag_pos, flag_neg}) == 1);
endmodule

// File: tb/acc_cpu_tb_top.sv
module acc_cpu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 256;

  typedef struct packed {
    logic [7:0]  opc;
    logic [23:0] field;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] exp;
  } vec_t;

  // program per vector: LOD 100 ; <opc field> ; STO 102 ; HLT
  localparam int NVEC = 9;
  localparam vec_t VECS [0:NVEC-1] = '{
    '{8'd3,  24'd101,      32'hFFFF_FFFF, 32'd2,         32'd1},          // R3 add wraps
    '{8'd3,  24'd101,      32'd5,         32'd7,         32'd12},         // R3 add
    '{8'd4,  24'd101,      32'd3,         32'd5,         32'hFFFF_FFFE},  // R3 sub negative
    '{8'd4,  24'd101,      32'h10,        32'h10,        32'd0},          // R3 sub to zero
    '{8'd12, 24'd101,      32'hF0F0_0000, 32'h0000_000F, 32'hF0F0_000F},  // R3 or
    '{8'd13, 24'd101,      32'hFF00_FF00, 32'h0F0F_0F0F, 32'h0F00_0F00},  // R3 and
    '{8'd14, 24'hABCDEF,   32'h1234_5678, 32'd0,         32'hEDCB_A987},  // R8 not
    '{8'd0,  24'hFFFFFF,   32'h8000_0000, 32'd0,         32'h00FF_FFFF},  // R1 literal
    '{8'd1,  24'd101,      32'd1,         32'hDEAD_BEEF, 32'hDEAD_BEEF}   // R3 load
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_rd_en, mem_wr_en;
  logic [31:0] mem_wdata, mem_rdata;
  logic [7:0]  in_char = 8'h00;
  logic        in_valid, in_ready;
  logic [7:0]  out_char;
  logic        out_valid, out_ready;
  logic        halted;
  logic [15:0] prog_counter;
  logic [31:0] acc_value;
  logic        flag_zero, flag_pos, flag_neg;

  logic [31:0] mem [0:MEM_WORDS-1];
  int n_checks = 0;
  int n_errors = 0;
  int src_hold = 0;
  int sink_hold = 0;
  int in_wait, out_wait;
  int wr_cnt, rd_after_halt, in_stall, out_stall, out_n;
  logic [7:0] chars [0:3];
  logic        got_first;
  logic [15:0] first_rd_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_cpu dut_i (
    .clk(clk), .rst_n(rst_n),
    .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .in_char(in_char), .in_valid(in_valid), .in_ready(in_ready),
    .out_char(out_char), .out_valid(out_valid), .out_ready(out_ready),
    .halted(halted), .prog_counter(prog_counter), .acc_value(acc_value),
    .flag_zero(flag_zero), .flag_pos(flag_pos), .flag_neg(flag_neg)
  );

  // synchronous memory model, one-cycle read latency
  always @(posedge clk) begin
    if (mem_wr_en) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd_en) mem_rdata <= mem[mem_addr[7:0]];
  end

  // character source with programmable delay
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_valid <= 1'b0; in_wait <= 0;
    end else if (in_valid && in_ready) begin
      in_valid <= 1'b0; in_wait <= 0;
    end else if (in_ready && !in_valid) begin
      if (in_wait >= src_hold) in_valid <= 1'b1;
      else in_wait <= in_wait + 1;
    end
  end

  // character sink with programmable delay
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_ready <= 1'b0; out_wait <= 0;
    end else if (out_valid && out_ready) begin
      out_ready <= 1'b0; out_wait <= 0;
    end else if (out_valid && !out_ready) begin
      if (out_wait >= sink_hold) out_ready <= 1'b1;
      else out_wait <= out_wait + 1;
    end
  end

  // monitors
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_cnt <= 0; rd_after_halt <= 0; in_stall <= 0; out_stall <= 0;
      out_n <= 0; got_first <= 1'b0; first_rd_addr <= 16'hFFFF;
    end else begin
      if (mem_wr_en) wr_cnt <= wr_cnt + 1;
      if (halted && (mem_rd_en || mem_wr_en)) rd_after_halt <= rd_after_halt + 1;
      if (in_ready && !in_valid) in_stall <= in_stall + 1;
      if (out_valid && !out_ready) out_stall <= out_stall + 1;
      if (out_valid && out_ready) begin
        if (out_n < 4) chars[out_n] <= out_char;
        out_n <= out_n + 1;
      end
      if (mem_rd_en && !got_first) begin
        got_first <= 1'b1; first_rd_addr <= mem_addr;
      end
    end
  end

  function automatic logic [31:0] w(input logic [7:0] op, input logic [23:0] f);
    return {op, f};
  endfunction

  function automatic logic [2:0] exp_flags(input logic [31:0] v);
    if (v == 32'd0) return 3'b100;
    if (v[31])      return 3'b001;
    return 3'b010;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = 32'd0;
  endtask

  task automatic run_prog();
    bit done;
    done = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (halted) begin
        done = 1'b1;
        break;
      end
    end
    chk("R11 halt reached", 32'(done), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++; n_checks++;
    $display("FAIL watchdog all requirements: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    // reset state (R12)
    clear_mem();
    mem[0] = w(8'd7, 24'd0);
    repeat (3) @(negedge clk);
    chk("R12 halted in reset", 32'(halted), 32'd0);
    chk("R12 pc in reset", 32'(prog_counter), 32'd0);
    chk("R12 acc in reset", acc_value, 32'd0);
    chk("R12 strobes in reset", 32'({mem_rd_en, mem_wr_en}), 32'd0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk("R12 first fetch address", 32'(first_rd_addr), 32'd0);
    chk("R11 halt on opcode 7 pc", 32'(prog_counter), 32'd1);

    // table of ALU/literal vectors (R1 R3 R4 R6 R8 R2)
    for (int i = 0; i < NVEC; i++) begin
      clear_mem();
      mem[0]   = w(8'd1, 24'd100);
      mem[1]   = w(VECS[i].opc, VECS[i].field);
      mem[2]   = w(8'd2, 24'd102);
      mem[3]   = w(8'd7, 24'd0);
      mem[100] = VECS[i].a;
      mem[101] = VECS[i].b;
      mem[102] = 32'h5A5A_5A5A;
      run_prog();
      chk($sformatf("R3 vector %0d accumulator", i), acc_value, VECS[i].exp);
      chk($sformatf("R4 vector %0d stored word", i), mem[102], VECS[i].exp);
      chk($sformatf("R4 vector %0d write count", i), 32'(wr_cnt), 32'd1);
      chk($sformatf("R6 vector %0d flags", i),
          32'({flag_zero, flag_pos, flag_neg}), 32'(exp_flags(VECS[i].exp)));
      chk($sformatf("R2 vector %0d pc after halt", i), 32'(prog_counter), 32'd4);
    end

    // skips (R7): LOD 100 ; skip ; LIT 9 ; STO 110 ; HLT
    for (int k = 0; k < 6; k++) begin
      logic [7:0]  sop;
      logic [31:0] val;
      bit          taken;
      case (k)
        0: begin sop = 8'd9;  val = 32'd0;         taken = 1'b1; end
        1: begin sop = 8'd9;  val = 32'd5;         taken = 1'b0; end
        2: begin sop = 8'd10; val = 32'd5;         taken = 1'b1; end
        3: begin sop = 8'd10; val = 32'h8000_0000; taken = 1'b0; end
        4: begin sop = 8'd11; val = 32'h8000_0000; taken = 1'b1; end
        default: begin sop = 8'd11; val = 32'd0;   taken = 1'b0; end
      endcase
      clear_mem();
      mem[0] = w(8'd1, 24'd100);
      mem[1] = w(sop, 24'd0);
      mem[2] = w(8'd0, 24'd9);
      mem[3] = w(8'd2, 24'd110);
      mem[4] = w(8'd7, 24'd0);
      mem[100] = val;
      mem[110] = 32'h55;
      run_prog();
      chk($sformatf("R7 skip case %0d stored", k), mem[110], taken ? val : 32'd9);
      chk($sformatf("R7 skip case %0d pc", k), 32'(prog_counter), 32'd5);
    end

    // jump (R5)
    clear_mem();
    mem[0] = w(8'd8, 24'd5);
    mem[1] = w(8'd0, 24'd1);
    mem[2] = w(8'd2, 24'd110);
    mem[3] = w(8'd7, 24'd0);
    mem[5] = w(8'd0, 24'd7);
    mem[6] = w(8'd2, 24'd110);
    mem[7] = w(8'd7, 24'd0);
    run_prog();
    chk("R5 jump target executed", mem[110], 32'd7);
    chk("R5 pc after jump path", 32'(prog_counter), 32'd8);

    // character input and output (R9 R10)
    clear_mem();
    src_hold = 6; sink_hold = 4; in_char = 8'hC3;
    mem[0] = w(8'd5, 24'd0);
    mem[1] = w(8'd2, 24'd110);
    mem[2] = w(8'd6, 24'd0);
    mem[3] = w(8'd0, 24'h41);
    mem[4] = w(8'd6, 24'd0);
    mem[5] = w(8'd7, 24'd0);
    mem[110] = 32'h55;
    run_prog();
    chk("R9 input zero-extended", mem[110], 32'h0000_00C3);
    chk("R9 input stall observed", 32'(in_stall >= 6), 32'd1);
    chk("R10 character count", 32'(out_n), 32'd2);
    chk("R10 first character", 32'(chars[0]), 32'hC3);
    chk("R10 second character", 32'(chars[1]), 32'h41);
    chk("R10 output stall observed", 32'(out_stall >= 8), 32'd1);
    chk("R2 pc after io program", 32'(prog_counter), 32'd6);

    // undefined opcodes halt (R11)
    clear_mem();
    mem[0] = w(8'd0, 24'd3);
    mem[1] = w(8'd15, 24'd0);
    mem[2] = w(8'd0, 24'd9);
    mem[3] = w(8'd2, 24'd110);
    mem[4] = w(8'd7, 24'd0);
    mem[110] = 32'h55;
    run_prog();
    repeat (20) @(negedge clk);
    chk("R11 opcode 15 pc", 32'(prog_counter), 32'd2);
    chk("R11 opcode 15 accumulator", acc_value, 32'd3);
    chk("R11 no execution after halt", mem[110], 32'h55);
    chk("R11 no memory access after halt", 32'(rd_after_halt), 32'd0);

    clear_mem();
    mem[0] = w(8'd0, 24'd1);
    mem[1] = w(8'd0, 24'd2);
    mem[2] = w(8'hFF, 24'd0);
    run_prog();
    chk("R11 opcode 255 pc", 32'(prog_counter), 32'd3);
    chk("R1 literal before halt", acc_value, 32'd2);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule